// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Slave

This block is the control port of a tuner's frequency synthesizer. It sits on a two-wire I2C bus as a slave. It holds the divider, reference and port settings that the synthesizer core reads. It also answers status reads with a power-on flag, the loop lock indication and a 3-bit level code produced elsewhere on the chip.

A write transfer starts with the address byte. The data bytes that follow are sorted into two groups by their most significant bit: a divider group of two bytes and a control group whose two bytes each take effect alone. The divider group is applied only when both of its bytes have arrived. An interrupted transfer therefore leaves the earlier settings in force, and a short three-byte frequency change is legal. The two bus lines are oversampled by the system clock, which must run at least eight times faster than SCL. START, STOP and the clock edges are found from the synchronized samples.

Top module: `tuner_i2c_ctl`

## Requirements
- R1: After reset every programmed output (div_m, swallow, ref_code, pre_half, cp_hi, vari_off, port_out) is 0 and sda_oe is 0.
- R2: The slave acknowledges only the address byte {5'b11000, addr_sel[1], addr_sel[0], rw}. With any other address it does not pull SDA low during that acknowledge or during any later byte, and no output changes until the next START.
- R3: A write data byte decoded with bit 7 = 0 is divider byte one; its bits 6..0 become div_m[10:4]. The next byte supplies div_m[3:0] from its bits 7..4 and swallow from its bits 3..0. All of these fields change together, only after that second byte, and that second byte is never decoded by its bit 7.
- R4: A write data byte decoded with bit 7 = 1 is control byte one and takes effect at once. Bit 6 drives div_m[12], bit 5 drives div_m[11], bit 4 drives pre_half and bits 3..0 drive ref_code.
- R5: The byte after control byte one is control byte two and takes effect on its own. Bit 7 drives vari_off, bit 6 drives cp_hi and bits 3..0 drive port_out; bits 5 and 4 are ignored.
- R6: A transfer that ends with a STOP after divider byte one leaves div_m and swallow unchanged.
- R7: After a group completes, the next byte is decoded again by its bit 7. The groups may come in either order within one transfer, and at most one group commits in any cycle.
- R8: A repeated START followed by an address begins a new transfer. A half-received divider group is discarded, and the next data byte is decoded by its bit 7.
- R9: In a read, the slave returns the status byte {pr, lock_i, 1, 1, 1, level_i[2:0]}, most significant bit first.
- R10: pr is 1 after reset and becomes 0 once a status byte has been fully shifted out. A second status byte in the same read, after a master ACK, already shows pr = 0.
- R11: The slave acknowledges every write data byte after an address match. After the master NACKs a status byte, the slave releases SDA, and SDA is released after any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 2 | Hardware address select, forms address bits 2..1 |
| lock_i | input | 1 | Synthesizer lock indication |
| level_i | input | 3 | Level code reported in the status byte |
| div_m | output | 13 | Main divider word |
| swallow | output | 4 | Swallow counter value |
| ref_code | output | 4 | Reference divider select code |
| pre_half | output | 1 | Adds the divide-by-two prescaler stage |
| cp_hi | output | 1 | Selects the higher charge-pump current |
| vari_off | output | 1 | Turns the tuning-voltage driver off |
| port_out | output | 4 | General-purpose port bits |

## Verification
Two behaviours meet in one read: the clearing of the power-on flag when a status byte finishes, and the loading of the next status byte after a master ACK. The bench provokes this by acknowledging the first status byte and clocking a second one. It expects pr = 1 in the first byte and pr = 0 in the second, so a clear that lands late or a snapshot taken early is caught. A second meeting is a repeated START that arrives while a divider group is half received. The bench follows it with a byte that has bit 7 = 0 and judges the divider word that results.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } bus_st_t;

  typedef enum logic [1:0] {G_ANY, G_DIV2, G_CTL2} grp_t;

  localparam logic [4:0] DEV_ID = 5'b11000;

  // address byte compare: fixed id, two select bits, rw bit excluded
  function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] sel);
    return b[7:1] == {DEV_ID, sel};
  endfunction

  // reported status layout
  function automatic logic [7:0] status_pack(input logic pr, input logic fl,
                                             input logic [2:0] lvl);
    return {pr, fl, 3'b111, lvl};
  endfunction

  // lower 11 divider bits from the held first byte and the second byte
  function automatic logic [10:0] div_low_word(input logic [6:0] hold,
                                               input logic [7:0] b);
    return {hold, b[7:4]};
  endfunction

endpackage

// File: rtl/tpll_line_sync.sv
module tpll_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_q, sda_q;
  logic          scl_p, sda_p, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[LAST-1:0], scl_i};
          sda_q <= {sda_q[LAST-1:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  assign scl_s     = scl_q[LAST];
  assign sda_s     = sda_q[LAST];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tpll_byte_fsm.sv
module tpll_byte_fsm
  import tpll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       wr_byte_evt,
  output logic [7:0] wr_byte,
  output logic       status_done
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(8);

  bus_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh, tx;
  logic             rw, ack_drv, m_ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '1;
      rw <= 1'b0; ack_drv <= 1'b0; m_ack <= 1'b0;
    end else if (start_evt) begin
      st <= S_ADDR; cnt <= '0; ack_drv <= 1'b0;
    end else if (stop_evt) begin
      st <= S_IDLE; ack_drv <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WDAT: begin
          if (scl_rise && cnt != FULL) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          if (scl_fall && cnt == FULL) begin
            if (st == S_WDAT) begin
              st <= S_WACK; ack_drv <= 1'b1;
            end else if (addr_hit(sh, addr_sel)) begin
              st <= S_AACK; ack_drv <= 1'b1; rw <= sh[0];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          ack_drv <= 1'b0; cnt <= '0;
          if (rw) begin
            tx <= status_byte; st <= S_RDAT;
          end else begin
            st <= S_WDAT;
          end
        end
        S_WACK: if (scl_fall) begin
          ack_drv <= 1'b0; cnt <= '0; st <= S_WDAT;
        end
        S_RDAT: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          if (scl_fall) begin
            if (cnt == FULL) st <= S_RACK;
            else             tx <= {tx[6:0], 1'b1};
          end
        end
        S_RACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          if (scl_fall) begin
            if (m_ack) begin
              tx <= status_byte; cnt <= '0; st <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  assign wr_byte     = sh;
  assign wr_byte_evt = (st == S_WDAT) && scl_fall && (cnt == FULL) && !start_evt && !stop_evt;
  assign status_done = (st == S_RDAT) && scl_rise && (cnt == FULL - 1'b1) && !start_evt && !stop_evt;
  assign sda_oe      = ack_drv | ((st == S_RDAT) & ~tx[7]);
endmodule

// File: rtl/tpll_regs.sv
module tpll_regs
  import tpll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txn_start,
  input  logic        wr_byte_evt,
  input  logic [7:0]  wr_byte,
  input  logic        status_done,
  output logic [12:0] div_m,
  output logic [3:0]  swallow,
  output logic [3:0]  ref_code,
  output logic        pre_half,
  output logic        cp_hi,
  output logic        vari_off,
  output logic [3:0]  port_out,
  output logic        pr_flag,
  output logic        div_commit,
  output logic        ctl1_commit,
  output logic        ctl2_commit
);
  grp_t       grp;
  logic [6:0] hold;

  assign div_commit  = wr_byte_evt && grp == G_DIV2;
  assign ctl1_commit = wr_byte_evt && grp == G_ANY && wr_byte[7];
  assign ctl2_commit = wr_byte_evt && grp == G_CTL2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grp <= G_ANY; hold <= '0;
    end else if (txn_start) begin
      grp <= G_ANY;
    end else if (wr_byte_evt) begin
      case (grp)
        G_ANY: begin
          if (wr_byte[7]) grp <= G_CTL2;
          else begin
            grp  <= G_DIV2;
            hold <= wr_byte[6:0];
          end
        end
        default: grp <= G_ANY;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_m <= '0; swallow <= '0; ref_code <= '0; pre_half <= 1'b0;
      cp_hi <= 1'b0; vari_off <= 1'b0; port_out <= '0;
    end else begin
      if (div_commit) begin
        div_m[10:0] <= div_low_word(hold, wr_byte);
        swallow     <= wr_byte[3:0];
      end
      if (ctl1_commit) begin
        div_m[12:11] <= wr_byte[6:5];
        pre_half     <= wr_byte[4];
        ref_code     <= wr_byte[3:0];
      end
      if (ctl2_commit) begin
        vari_off <= wr_byte[7];
        cp_hi    <= wr_byte[6];
        port_out <= wr_byte[3:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           pr_flag <= 1'b1;
    else if (status_done) pr_flag <= 1'b0;
endmodule

// File: rtl/tuner_i2c_ctl.sv
module tuner_i2c_ctl
  import tpll_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        lock_i,
  input  logic [2:0]  level_i,
  output logic [12:0] div_m,
  output logic [3:0]  swallow,
  output logic [3:0]  ref_code,
  output logic        pre_half,
  output logic        cp_hi,
  output logic        vari_off,
  output logic [3:0]  port_out
);
  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_byte_evt, status_done, pr_flag;
  logic       div_commit, ctl1_commit, ctl2_commit;
  logic [7:0] wr_byte, status_byte;

  assign status_byte = status_pack(pr_flag, lock_i, level_i);

  tpll_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tpll_byte_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_sel(addr_sel), .status_byte(status_byte), .sda_oe(sda_oe),
    .wr_byte_evt(wr_byte_evt), .wr_byte(wr_byte), .status_done(status_done)
  );

  tpll_regs u_regs (
    .clk(clk), .rst_n(rst_n), .txn_start(start_evt),
    .wr_byte_evt(wr_byte_evt), .wr_byte(wr_byte), .status_done(status_done),
    .div_m(div_m), .swallow(swallow), .ref_code(ref_code),
    .pre_half(pre_half), .cp_hi(cp_hi), .vari_off(vari_off),
    .port_out(port_out), .pr_flag(pr_flag), .div_commit(div_commit),
    .ctl1_commit(ctl1_commit), .ctl2_commit(ctl2_commit)
  );
endmodule

// File: rtl/tpll_chk.sv
module tpll_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        stop_evt,
  input logic        status_done,
  input logic        pr_flag,
  input logic        div_commit,
  input logic        ctl1_commit,
  input logic        ctl2_commit,
  input logic [12:0] div_m,
  input logic [3:0]  swallow,
  input logic [3:0]  ref_code,
  input logic        pre_half,
  input logic        cp_hi,
  input logic        vari_off,
  input logic [3:0]  port_out
);
  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !div_commit |=> $stable({div_m[10:0], swallow}));

  p_ctl1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl1_commit |=> $stable({div_m[12:11], pre_half, ref_code}));

  p_ctl2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl2_commit |=> $stable({vari_off, cp_hi, port_out}));

  p_one_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_commit, ctl1_commit, ctl2_commit}));

  p_pr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_done |=> !pr_flag);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind tuner_i2c_ctl tpll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .stop_evt(stop_evt),
  .status_done(status_done), .pr_flag(pr_flag), .div_commit(div_commit),
  .ctl1_commit(ctl1_commit), .ctl2_commit(ctl2_commit), .div_m(div_m),
  .swallow(swallow), .ref_code(ref_code), .pre_half(pre_half),
  .cp_hi(cp_hi), .vari_off(vari_off), .port_out(port_out)
);

// File: tb/tuner_i2c_ctl_bench.sv
module tuner_i2c_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m_low = 1'b0;
  logic        sda_oe;
  logic        sda_line;
  logic [1:0]  addr_sel = 2'b10;
  logic        lock_i = 1'b0;
  logic [2:0]  level_i = 3'b000;
  logic [12:0] div_m;
  logic [3:0]  swallow, ref_code, port_out;
  logic        pre_half, cp_hi, vari_off;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;
  assign sda_line = ~(sda_m_low | sda_oe);

  tuner_i2c_ctl u_tuner_i2c_ctl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .level_i(level_i), .div_m(div_m),
    .swallow(swallow), .ref_code(ref_code), .pre_half(pre_half),
    .cp_hi(cp_hi), .vari_off(vari_off), .port_out(port_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m_low = 1'b0; qwait;
    scl_m = 1'b1; qwait;
    sda_m_low = 1'b1; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m_low = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    sda_m_low = 1'b0; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m_low = ~b[i]; qwait;
      scl_m = 1'b1; qwait; qwait;
      scl_m = 1'b0; qwait;
    end
    sda_m_low = 1'b0; qwait;
    scl_m = 1'b1; qwait;
    ack = ~sda_line; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    sda_m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait;
      scl_m = 1'b1; qwait;
      b[i] = sda_line; qwait;
      scl_m = 1'b0;
    end
    sda_m_low = give_ack; qwait;
    scl_m = 1'b1; qwait; qwait;
    scl_m = 1'b0; qwait;
    sda_m_low = 1'b0;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] sel, input logic rd);
    return {5'b11000, sel, rd};
  endfunction

  task automatic write_seq(input string tag, input logic [7:0] d0, input logic [7:0] d1,
                           input int n);
    logic a;
    bus_start;
    send_byte(addr_byte(addr_sel, 1'b0), a); chk({tag, " R2 addr ack"}, a, 1);
    send_byte(d0, a); chk({tag, " R11 ack"}, a, 1);
    if (n > 1) begin
      send_byte(d1, a); chk({tag, " R11 ack"}, a, 1);
    end
  endtask

  task automatic t_reset;
    chk("R1 div_m", div_m, 0);
    chk("R1 swallow", swallow, 0);
    chk("R1 ctl", {ref_code, pre_half, cp_hi, vari_off, port_out}, 0);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_status;
    logic a;
    logic [7:0] b;
    lock_i = 1'b1; level_i = 3'b101;
    bus_start;
    send_byte(addr_byte(addr_sel, 1'b1), a); chk("R2 read addr ack", a, 1);
    read_byte(1'b1, b); chk("R9 R10 first status pr=1", b, 8'hFD);
    read_byte(1'b0, b); chk("R10 second status pr=0", b, 8'h7D);
    chk("R11 released after nack", sda_line, 1);
    bus_stop;
    chk("R11 released after stop", sda_oe, 0);
    lock_i = 1'b0; level_i = 3'b010;
    bus_start;
    send_byte(addr_byte(addr_sel, 1'b1), a);
    read_byte(1'b0, b); chk("R9 status lock=0 level=2", b, 8'h3A);
    bus_stop;
  endtask

  task automatic t_divider;
    logic a;
    bus_start;
    send_byte(addr_byte(addr_sel, 1'b0), a); chk("R2 write addr ack", a, 1);
    send_byte(8'h35, a); chk("R11 div1 ack", a, 1);
    chk("R3 no change after byte one", {div_m, swallow}, 0);
    send_byte(8'hA7, a); chk("R11 div2 ack", a, 1);
    bus_stop;
    chk("R3 div_m", div_m, 13'h035A);
    chk("R3 swallow", swallow, 4'h7);
    chk("R3 second byte msb=1 not control", {pre_half, ref_code}, 0);
  endtask

  task automatic t_control;
    write_seq("ctl", 8'hD9, 8'h00, 1);
    chk("R4 div_m high bits", div_m, 13'h135A);
    chk("R4 pre_half", pre_half, 1);
    chk("R4 ref_code", ref_code, 4'h9);
    chk("R5 ctl2 untouched by ctl1", {vari_off, cp_hi, port_out}, 0);
    begin
      logic a;
      send_byte(8'hF6, a); chk("R11 ctl2 ack", a, 1);
    end
    bus_stop;
    chk("R5 vari_off", vari_off, 1);
    chk("R5 cp_hi", cp_hi, 1);
    chk("R5 port_out", port_out, 4'h6);
    chk("R5 divider untouched", {div_m, swallow}, {13'h135A, 4'h7});
  endtask

  task automatic t_partial;
    write_seq("partial", 8'h7F, 8'h00, 1);
    bus_stop;
    chk("R6 div_m kept", div_m, 13'h135A);
    chk("R6 swallow kept", swallow, 4'h7);
    write_seq("partial", 8'h80, 8'h00, 1);
    bus_stop;
    chk("R4 ctl1 alone", {div_m, pre_half, ref_code}, {13'h035A, 1'b0, 4'h0});
    chk("R5 ctl2 kept", {vari_off, cp_hi, port_out}, {2'b11, 4'h6});
  endtask

  task automatic t_restart;
    write_seq("restart", 8'h11, 8'h00, 1);
    write_seq("restart", 8'h05, 8'h3C, 2);
    bus_stop;
    chk("R8 div_m after repeated start", div_m, 13'h0053);
    chk("R8 swallow after repeated start", swallow, 4'hC);
  endtask

  task automatic t_bad_addr;
    logic a;
    bus_start;
    send_byte(addr_byte(2'b01, 1'b0), a); chk("R2 wrong addr nack", a, 0);
    send_byte(8'h00, a); chk("R2 no ack after mismatch", a, 0);
    send_byte(8'h00, a); chk("R2 no ack after mismatch", a, 0);
    send_byte(8'h80, a);
    bus_stop;
    chk("R2 outputs untouched", {div_m, swallow, ref_code, pre_half},
        {13'h0053, 4'hC, 4'h0, 1'b0});
  endtask

  task automatic t_sequence;
    logic a;
    write_seq("seq", 8'hB4, 8'h09, 2);
    send_byte(8'h7E, a); chk("R7 ack", a, 1);
    send_byte(8'h5F, a); chk("R7 ack", a, 1);
    bus_stop;
    chk("R7 div_m", div_m, 13'h0FE5);
    chk("R7 swallow", swallow, 4'hF);
    chk("R7 ctl1", {pre_half, ref_code}, {1'b1, 4'h4});
    chk("R7 ctl2", {vari_off, cp_hi, port_out}, {2'b00, 4'h9});
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    qwait;
    t_reset;
    t_status;
    t_divider;
    t_control;
    t_partial;
    t_restart;
    t_bad_addr;
    t_sequence;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule